// File: doc/BRIEF.md
# HDLC transmit stop/restart controller

This block sits between a queue of outgoing frames and the bit-level HDLC framer. Frames arrive as a byte stream with start-of-frame and end-of-frame markers and a ready/valid handshake. The block passes them on toward the framer, one byte per cycle, through one output register. Bit stuffing, CRC generation and serialisation happen downstream.

A host steers transmission with a command strobe and a two-bit opcode. An abrupt stop cuts the frame in progress short and tells the framer to abort it. A graceful stop lets the current frame run to its end and only then halts. This is how a high-priority frame gets placed ahead of the queue without an abort. A restart resumes service from the queue. While halted, the framer is told to send line fill, which is either idles or repeated flags as set by a configuration bit. When a graceful stop completes, an event bit is set. Software clears it by writing one, and it can raise a maskable interrupt.

Top module: `hdlc_tx_halt_ctrl`

## Requirements
- R1: A byte accepted within a frame (`src_valid && src_ready`) appears on `tx_data` with `tx_valid=1` after the next rising clock edge, and its `src_sof`/`src_eof` markers are copied to `tx_sof`/`tx_eof`.
- R2: Opcode 2'b01 (stop) drops `src_ready` in the same cycle it is strobed, and the controller halts. If a frame was in progress, `tx_abort` is 1 for exactly the one output cycle that follows, with `tx_valid=0`.
- R3: While halted, `tx_valid=0` and `tx_fill=1`. `tx_data` is 8'hFF in every byte lane when `cfg_fill_flags=0` and 8'h7E when it is 1. No source byte is accepted.
- R4: Opcode 2'b11 (restart) while halted ends the fill in the next output cycle, and `src_ready` returns in the cycle after the command.
- R5: A byte accepted outside a frame without `src_sof` is consumed and discarded. This flushes the remainder of an aborted frame after a restart.
- R6: Opcode 2'b10 (graceful stop) lets the current frame continue through its end-of-frame byte and then halts. No new start-of-frame byte is accepted once it is pending. With no frame in progress, it halts one cycle after the command.
- R7: `evt_grace` is set at the edge where a graceful stop takes effect. `irq` equals `evt_grace` ANDed with `irq_mask`.
- R8: Holding `evt_clr=1` across a clock edge clears `evt_grace`, unless a graceful stop completes at that same edge.
- R9: A stop command while a graceful stop is pending converts it into an immediate stop: an abort is sent if a frame is in progress, and `evt_grace` is not set.
- R10: Restart while running, and graceful stop while halted, have no effect on state or outputs.
- R11: After reset, the controller is running with `src_ready=1`, all `tx_*` outputs 0, `evt_grace=0` and `irq=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Opcode: 01 stop, 10 graceful stop, 11 restart, 00 none |
| cfg_fill_flags | input | 1 | Fill select: 0 idle (all ones), 1 flag (0x7E) |
| src_valid | input | 1 | Source byte valid |
| src_data | input | DATA_W | Source data |
| src_sof | input | 1 | Source byte opens a frame |
| src_eof | input | 1 | Source byte closes a frame |
| src_ready | output | 1 | Controller accepts the source byte this cycle |
| tx_valid | output | 1 | Frame byte toward the framer |
| tx_data | output | DATA_W | Frame byte, or the fill pattern while halted |
| tx_sof | output | 1 | Frame byte opens a frame |
| tx_eof | output | 1 | Frame byte closes a frame |
| tx_abort | output | 1 | Framer must abort the open frame |
| tx_fill | output | 1 | Framer must send the fill pattern on `tx_data` |
| evt_clr | input | 1 | Write-one-to-clear for the event bit |
| irq_mask | input | 1 | Interrupt enable for the event bit |
| evt_grace | output | 1 | Graceful stop completed |
| irq | output | 1 | Masked interrupt |

## Verification
The bench walks a single scripted sequence and then targets the hard corners. The first is a stop in the middle of a frame: a design that held `src_ready` high that cycle would lose or duplicate a byte, and one that skipped the abort would let a partial frame close cleanly. The second is the stale tail of an aborted frame after restart: a design that forwarded it would emit bytes with no start marker. A graceful stop is issued both mid-frame and with no frame open; an early or missing halt, or an event on the wrong cycle, shows up directly. The bench also converts a pending graceful stop into an abrupt one and checks that no event appears. It switches fill polarity while halted, clears the event, and tests the mask.

// File: rtl/hdlc_halt_pkg.sv
package hdlc_halt_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_STOP   = 2'b01,
      OP_GRACE  = 2'b10,
      OP_RESUME = 2'b11
   } halt_op_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'b00,
      ST_GPEND = 2'b01,
      ST_HALT  = 2'b10
   } halt_st_e;

   localparam logic [7:0] IDLE_BYTE = 8'hFF;
   localparam logic [7:0] FLAG_BYTE = 8'h7E;

endpackage

// File: rtl/halt_fsm.sv
module halt_fsm
   import hdlc_halt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       src_valid,
   input  logic       src_sof,
   input  logic       src_eof,
   output logic       src_ready,
   output logic       fwd,
   output logic       abort_now,
   output logic       grace_done,
   output logic       halt_next
);

   halt_st_e st_q, st_d;
   logic     in_frame_q, in_frame_d;
   logic     stop_cmd, grace_cmd, resume_cmd;
   logic     accept, frame_end;

   assign stop_cmd   = cmd_valid && (cmd_op == OP_STOP);
   assign grace_cmd  = cmd_valid && (cmd_op == OP_GRACE);
   assign resume_cmd = cmd_valid && (cmd_op == OP_RESUME);

   assign src_ready = ((st_q == ST_RUN) || ((st_q == ST_GPEND) && in_frame_q)) && !stop_cmd;
   assign accept    = src_valid && src_ready;
   assign fwd       = accept && (in_frame_q || src_sof);
   assign frame_end = fwd && src_eof;
   assign abort_now = stop_cmd && in_frame_q;

   always_comb begin
      st_d       = st_q;
      grace_done = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            if (stop_cmd)       st_d = ST_HALT;
            else if (grace_cmd) st_d = ST_GPEND;
         end
         ST_GPEND: begin
            if (stop_cmd)        st_d = ST_HALT;
            else if (resume_cmd) st_d = ST_RUN;
            else if (frame_end || !in_frame_q) begin
               st_d       = ST_HALT;
               grace_done = 1'b1;
            end
         end
         ST_HALT: begin
            if (resume_cmd) st_d = ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   assign halt_next = (st_d == ST_HALT);

   always_comb begin
      in_frame_d = in_frame_q;
      if (stop_cmd)  in_frame_d = 1'b0;
      else if (fwd)  in_frame_d = !src_eof;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         in_frame_q <= 1'b0;
      end else begin
         st_q       <= st_d;
         in_frame_q <= in_frame_d;
      end
   end

   assert_stop_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> (st_q == ST_HALT));

   assert_no_accept_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT) |-> !src_ready);

   assert_pending_no_new_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_GPEND) && !in_frame_q) |-> !src_ready);

   assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && resume_cmd) |=> (st_q == ST_RUN));

   assert_stop_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |-> !grace_done);

endmodule

// File: rtl/halt_tx_stage.sv
module halt_tx_stage
   import hdlc_halt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd,
   input  logic              abort_now,
   input  logic              halt_next,
   input  logic              flag_fill,
   input  logic [DATA_W-1:0] din,
   input  logic              dsof,
   input  logic              deof,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_sof,
   output logic              tx_eof,
   output logic              tx_abort,
   output logic              tx_fill
);

   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] idle_pat, flag_pat;

   if ((DATA_W % 8) != 0 || DATA_W == 0) begin : g_bad_width
      $error("halt_tx_stage: DATA_W must be a nonzero multiple of 8");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign idle_pat[g*8 +: 8] = IDLE_BYTE;
      assign flag_pat[g*8 +: 8] = FLAG_BYTE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
         tx_sof   <= 1'b0;
         tx_eof   <= 1'b0;
         tx_abort <= 1'b0;
         tx_fill  <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
         tx_sof   <= 1'b0;
         tx_eof   <= 1'b0;
         tx_abort <= 1'b0;
         tx_fill  <= 1'b0;
         if (fwd) begin
            tx_valid <= 1'b1;
            tx_data  <= din;
            tx_sof   <= dsof;
            tx_eof   <= deof;
         end else if (abort_now) begin
            tx_abort <= 1'b1;
         end else if (halt_next) begin
            tx_fill <= 1'b1;
            tx_data <= flag_fill ? flag_pat : idle_pat;
         end
      end
   end

   assert_out_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid, tx_abort, tx_fill}));

   assert_abort_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);

endmodule

// File: rtl/halt_event.sv
module halt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic mask,
   output logic evt,
   output logic irq
);

   logic evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     evt_q <= 1'b0;
      else if (set)   evt_q <= 1'b1;
      else if (clr)   evt_q <= 1'b0;
   end

   assign evt = evt_q;
   assign irq = evt_q & mask;

   assert_event_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> evt_q);

   assert_event_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !evt_q);

endmodule

// File: rtl/hdlc_tx_halt_ctrl.sv
module hdlc_tx_halt_ctrl
   import hdlc_halt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic              cfg_fill_flags,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_sof,
   input  logic              src_eof,
   output logic              src_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_sof,
   output logic              tx_eof,
   output logic              tx_abort,
   output logic              tx_fill,
   input  logic              evt_clr,
   input  logic              irq_mask,
   output logic              evt_grace,
   output logic              irq
);

   logic fwd, abort_now, grace_done, halt_next;

   halt_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .src_valid  (src_valid),
      .src_sof    (src_sof),
      .src_eof    (src_eof),
      .src_ready  (src_ready),
      .fwd        (fwd),
      .abort_now  (abort_now),
      .grace_done (grace_done),
      .halt_next  (halt_next)
   );

   halt_tx_stage #(.DATA_W(DATA_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .fwd       (fwd),
      .abort_now (abort_now),
      .halt_next (halt_next),
      .flag_fill (cfg_fill_flags),
      .din       (src_data),
      .dsof      (src_sof),
      .deof      (src_eof),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_sof    (tx_sof),
      .tx_eof    (tx_eof),
      .tx_abort  (tx_abort),
      .tx_fill   (tx_fill)
   );

   halt_event u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (grace_done),
      .clr   (evt_clr),
      .mask  (irq_mask),
      .evt   (evt_grace),
      .irq   (irq)
   );

   assert_abort_follows_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_now |=> (tx_abort && !tx_valid));

   assert_forward_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fwd |=> tx_valid);

endmodule

// File: tb/hdlc_tx_halt_ctrl_test.sv
module hdlc_tx_halt_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NROWS = 21;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic       cfg_fill_flags = 1'b1;
   logic       src_valid = 1'b0;
   logic [7:0] src_data = 8'h00;
   logic       src_sof = 1'b0;
   logic       src_eof = 1'b0;
   logic       src_ready;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_sof, tx_eof, tx_abort, tx_fill;
   logic       evt_clr = 1'b0;
   logic       irq_mask = 1'b1;
   logic       evt_grace, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_tx_halt_ctrl #(.DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cfg_fill_flags(cfg_fill_flags), .src_valid(src_valid), .src_data(src_data),
      .src_sof(src_sof), .src_eof(src_eof), .src_ready(src_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
      .tx_abort(tx_abort), .tx_fill(tx_fill), .evt_clr(evt_clr),
      .irq_mask(irq_mask), .evt_grace(evt_grace), .irq(irq)
   );

   // {cv, op[1:0], sv, sof, eof, d[7:0]} , {rdy, tv, tsof, teof, tab, tf, td[7:0], ev}
   localparam logic [28:0] ROWS [0:NROWS-1] = '{
      {1'b0,2'b00,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0},
      {1'b0,2'b00,1'b1,1'b1,1'b0,8'hA1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'hA1,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b0,8'hA2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hA2,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b1,8'hA3, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'hA3,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b0,8'h55, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0},
      {1'b0,2'b00,1'b1,1'b1,1'b0,8'hB1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'hB1,1'b0},
      {1'b1,2'b01,1'b1,1'b0,1'b0,8'hB2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b0,8'hB2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h7E,1'b0},
      {1'b1,2'b10,1'b1,1'b0,1'b0,8'hB2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h7E,1'b0},
      {1'b1,2'b11,1'b1,1'b0,1'b0,8'hB2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b0,8'hB2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0},
      {1'b0,2'b00,1'b1,1'b1,1'b0,8'hC1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'hC1,1'b0},
      {1'b1,2'b10,1'b1,1'b0,1'b0,8'hC2, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hC2,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b0,8'hC3, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'hC3,1'b0},
      {1'b0,2'b00,1'b1,1'b0,1'b1,8'hC4, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'hC4,1'b1},
      {1'b0,2'b00,1'b1,1'b1,1'b0,8'hD1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h7E,1'b1},
      {1'b1,2'b11,1'b1,1'b1,1'b0,8'hD1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1},
      {1'b0,2'b00,1'b1,1'b1,1'b0,8'hD1, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'hD1,1'b1},
      {1'b1,2'b11,1'b1,1'b0,1'b1,8'hD2, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'hD2,1'b1},
      {1'b1,2'b10,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1},
      {1'b0,2'b00,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h7E,1'b1}
   };

   localparam string ROW_REQ [0:NROWS-1] = '{
      "R11", "R1", "R1", "R1", "R5", "R1", "R2", "R3", "R10", "R4", "R5",
      "R1", "R6", "R6", "R7", "R6", "R4", "R4", "R10", "R10", "R6"
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic cv, input logic [1:0] op, input logic sv,
                        input logic sof, input logic eof, input logic [7:0] d);
      cmd_valid = cv; cmd_op = op; src_valid = sv;
      src_sof = sof; src_eof = eof; src_data = d;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      // R11: reset state
      chk("R11", "src_ready", 32'(src_ready), 32'd1);
      chk("R11", "tx outputs", 32'({tx_valid, tx_sof, tx_eof, tx_abort, tx_fill, tx_data}), 32'd0);
      chk("R11", "evt/irq", 32'({evt_grace, irq}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROWS; i++) begin
         logic [28:0] r;
         r = ROWS[i];
         drive(r[28], r[27:26], r[25], r[24], r[23], r[22:15]);
         #1;
         chk(ROW_REQ[i], $sformatf("row %0d src_ready", i), 32'(src_ready), 32'(r[14]));
         @(negedge clk);
         chk(ROW_REQ[i], $sformatf("row %0d tx flags", i),
             32'({tx_valid, tx_sof, tx_eof, tx_abort, tx_fill}), 32'(r[13:9]));
         chk(ROW_REQ[i], $sformatf("row %0d tx_data", i), 32'(tx_data), 32'(r[8:1]));
         chk(ROW_REQ[i], $sformatf("row %0d evt", i), 32'(evt_grace), 32'(r[0]));
      end
      drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00);

      // R7: irq follows event and mask
      chk("R7", "irq masked on", 32'(irq), 32'd1);
      irq_mask = 1'b0; #1;
      chk("R7", "irq masked off", 32'(irq), 32'd0);
      irq_mask = 1'b1;

      // R3: idle fill polarity while halted
      cfg_fill_flags = 1'b0;
      @(negedge clk);
      chk("R3", "idle fill data", 32'(tx_data), 32'hFF);
      chk("R3", "idle fill flag", 32'({tx_valid, tx_fill}), 32'b01);
      cfg_fill_flags = 1'b1;

      // R8: write one to clear the event
      evt_clr = 1'b1;
      @(negedge clk);
      evt_clr = 1'b0;
      chk("R8", "event cleared", 32'(evt_grace), 32'd0);
      chk("R8", "irq cleared", 32'(irq), 32'd0);

      // R9: stop during pending graceful stop becomes abrupt, no event
      drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      drive(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 8'hE1);
      @(negedge clk);
      chk("R9", "frame start", 32'({tx_valid, tx_data}), 32'h1E1);
      drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 8'hE2);
      @(negedge clk);
      chk("R9", "pending byte", 32'({tx_valid, tx_data}), 32'h1E2);
      drive(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 8'hE3);
      #1;
      chk("R9", "ready on stop", 32'(src_ready), 32'd0);
      @(negedge clk);
      drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R9", "abort", 32'({tx_valid, tx_abort}), 32'b01);
      chk("R9", "no event", 32'(evt_grace), 32'd0);
      @(negedge clk);
      chk("R9", "fill after abort", 32'({tx_abort, tx_fill}), 32'b01);
      chk("R9", "no event later", 32'(evt_grace), 32'd0);

      // R11: reset again from a halted state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", "reset tx", 32'({tx_valid, tx_abort, tx_fill, tx_data}), 32'd0);
      chk("R11", "reset ready", 32'(src_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule